// File: doc/BRIEF.md
# Strobe-Captured CAM Host Bus Decoder

This block sits at the host edge of a content-addressable lookup engine. It samples a slow, active-low enable strobe on the system clock. On each high-to-low transition of that strobe it latches the bus fields and the write word:

- the two chip selects
- the write enable
- the address-valid qualifier
- the 13-bit address/control field
- the half-word segment select
- the validity line
- the 32-bit write word

From these latched fields it issues one single-cycle request to the array and register logic behind it.

The shared address/control field is read in one of three ways:

- In hardware mode with address-valid low, it is a memory index for a random-access read or write.
- In hardware mode with address-valid high, it is a control code. A 4-bit opcode sits in bits 12:9 and a 4-bit register index sits in bits 3:0.
- In software mode the field is ignored. Address-valid then tells an instruction, taken from the low 12 data bits, from a plain data transfer.

For read cycles the block raises a data-port drive enable for as long as the strobe stays low. The caller supplies the read word and validity. This gives a 32-bit data port, plus the validity line, shown as separate output-data and drive-enable pairs.

Top module: `cam_bus_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every request output, `dq_oe` and `vb_oe` are low.
- R2: A cycle is decoded only on a strobe transition from high to low. It produces exactly one single-cycle request, in the clock cycle after the clock edge that first samples `strobe_n` low. Holding the strobe low produces nothing further.
- R3: The block is selected when `sel_a_n` or `sel_b_n` is low. A strobe with both selects high produces no request and no drive.
- R4: In hardware mode with `av_n` low, `wr_n` low gives `mem_wr` and `wr_n` high gives `mem_rd`. `tgt_addr` equals the latched 13-bit field. `entry_valid` equals the inverse of the latched `vb_n`, so a low validity line means valid and a high one means empty.
- R5: In hardware mode with `av_n` high and opcode 1 in bits 12:9, `wr_n` low gives `reg_wr` and high gives `reg_rd`. `tgt_addr` carries the index from bits 3:0, zero-extended.
- R6: Opcode 2 with `wr_n` low gives `cmp_req`, and `wr_data` carries the latched word. Opcode 3 gives `move_req` for either value of `wr_n`.
- R7: Opcode 2 with `wr_n` high, and every opcode other than 1, 2 and 3, produce no request and no drive.
- R8: `seg_sel` carries the latched segment select, where 1 means bits 63:32. A register access with segment select high to an index of `WIDE_REGS` (9) or above is a 32-bit register, and it is ignored.
- R9: `dq_oe` rises in the cycle after the edge that captures a read (`mem_rd`, `reg_rd` or `sw_data_rd`). It stays high until the cycle after the edge that samples `strobe_n` high. While it is high, `dq_out` equals `rd_data`. `vb_oe` is high only during memory reads.
- R10: In software mode, with `sw_mode` high, the address/control field is ignored and `tgt_addr` is 0. With `av_n` high and `wr_n` low the block gives `sw_instr` with `instr_code` equal to the write word's bits 11:0. With `av_n` high and `wr_n` high it gives nothing. With `av_n` low, `wr_n` low gives `sw_data_wr` and `wr_n` high gives `sw_data_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_mode | input | 1 | Software-control mode select |
| strobe_n | input | 1 | Active-low enable strobe |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b_n | input | 1 | Chip select B, active low |
| wr_n | input | 1 | Low: write into the block; high: read out |
| av_n | input | 1 | Address-valid qualifier |
| ac_bus | input | 13 | Address/control field |
| seg_hi | input | 1 | Half-word segment select |
| vb_n | input | 1 | Validity line input |
| dq_in | input | 32 | Write data |
| rd_data | input | 32 | Read word from the target |
| rd_vb_n | input | 1 | Read validity from the target |
| mem_wr | output | 1 | Memory write request |
| mem_rd | output | 1 | Memory read request |
| reg_wr | output | 1 | Register write request |
| reg_rd | output | 1 | Register read request |
| cmp_req | output | 1 | Compare request |
| move_req | output | 1 | Move request |
| sw_instr | output | 1 | Software instruction strobe |
| sw_data_wr | output | 1 | Software data write |
| sw_data_rd | output | 1 | Software data read |
| tgt_addr | output | 13 | Memory index or register index |
| seg_sel | output | 1 | Latched segment select |
| wr_data | output | 32 | Latched write word |
| entry_valid | output | 1 | Validity to store on memory write |
| instr_code | output | 12 | Latched instruction |
| dq_out | output | 32 | Data port output value |
| dq_oe | output | 1 | Data port drive enable |
| vb_out_n | output | 1 | Validity line output value |
| vb_oe | output | 1 | Validity line drive enable |

## Verification
The bench builds the decoder with its default parameters: a 13-bit field, a 4-bit opcode, a 4-bit register index and nine wide registers. With these values every opcode from 0 to 15 can be driven. Register indices 8 and 9 lie on either side of the boundary between the 64-bit and 32-bit registers, so the segment rule can be tested at that boundary. A full 13-bit address of all ones is also within reach. The reference model tracks the strobe history itself, which exposes repeated pulses when the strobe is held low and a late drop of the drive enable.

// File: rtl/cam_bus_pkg.sv
package cam_bus_pkg;

    typedef enum logic [3:0] {
        OPC_NONE = 4'h0,
        OPC_REG  = 4'h1,
        OPC_CMP  = 4'h2,
        OPC_MOVE = 4'h3
    } opcode_e;

    typedef struct packed {
        logic mem_wr;
        logic mem_rd;
        logic reg_wr;
        logic reg_rd;
        logic cmp;
        logic move;
        logic sw_instr;
        logic sw_dwr;
        logic sw_drd;
    } req_t;

endpackage

// File: rtl/cam_strobe_edge.sv
module cam_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strobe_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/cam_cycle_classify.sv
module cam_cycle_classify
    import cam_bus_pkg::*;
#(
    parameter int OP_W      = 4,
    parameter int IDX_W     = 4,
    parameter int WIDE_REGS = 9
) (
    input  logic             selected,
    input  logic             sw_mode,
    input  logic             wr_n,
    input  logic             av_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             seg_hi,
    output req_t             req,
    output logic             is_read
);
    localparam logic [IDX_W-1:0] WIDE_LIM = IDX_W'(WIDE_REGS);

    logic seg_ok;

    always_comb begin
        seg_ok = !seg_hi || (reg_idx < WIDE_LIM);
        req    = '0;
        if (selected) begin
            if (sw_mode) begin
                if (av_n) req.sw_instr = !wr_n;
                else begin
                    req.sw_dwr = !wr_n;
                    req.sw_drd = wr_n;
                end
            end else if (!av_n) begin
                req.mem_wr = !wr_n;
                req.mem_rd = wr_n;
            end else begin
                case (opcode)
                    OP_W'(OPC_REG): begin
                        req.reg_wr = !wr_n && seg_ok;
                        req.reg_rd = wr_n && seg_ok;
                    end
                    OP_W'(OPC_CMP):  req.cmp  = !wr_n;
                    OP_W'(OPC_MOVE): req.move = 1'b1;
                    default: ;
                endcase
            end
        end
        is_read = req.mem_rd | req.reg_rd | req.sw_drd;
    end
endmodule

// File: rtl/cam_bus_decoder.sv
module cam_bus_decoder
    import cam_bus_pkg::*;
#(
    parameter int AC_W      = 13,
    parameter int DW        = 32,
    parameter int INSTR_W   = 12,
    parameter int OP_W      = 4,
    parameter int IDX_W     = 4,
    parameter int WIDE_REGS = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_mode,
    input  logic               strobe_n,
    input  logic               sel_a_n,
    input  logic               sel_b_n,
    input  logic               wr_n,
    input  logic               av_n,
    input  logic [AC_W-1:0]    ac_bus,
    input  logic               seg_hi,
    input  logic               vb_n,
    input  logic [DW-1:0]      dq_in,
    input  logic [DW-1:0]      rd_data,
    input  logic               rd_vb_n,
    output logic               mem_wr,
    output logic               mem_rd,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic               cmp_req,
    output logic               move_req,
    output logic               sw_instr,
    output logic               sw_data_wr,
    output logic               sw_data_rd,
    output logic [AC_W-1:0]    tgt_addr,
    output logic               seg_sel,
    output logic [DW-1:0]      wr_data,
    output logic               entry_valid,
    output logic [INSTR_W-1:0] instr_code,
    output logic [DW-1:0]      dq_out,
    output logic               dq_oe,
    output logic               vb_out_n,
    output logic               vb_oe
);
    localparam int PAD_W = AC_W - IDX_W;

    typedef struct packed {
        req_t               req;
        logic [AC_W-1:0]    addr;
        logic               seg;
        logic [DW-1:0]      wdata;
        logic               ent_valid;
        logic [INSTR_W-1:0] instr;
        logic               oe;
        logic               vb_drive;
    } state_t;

    state_t s_d, s_q;
    logic   fall;
    logic   selected;
    req_t   cls_req;
    logic   cls_read;

    cam_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .fall     (fall)
    );

    assign selected = !sel_a_n || !sel_b_n;

    cam_cycle_classify #(
        .OP_W      (OP_W),
        .IDX_W     (IDX_W),
        .WIDE_REGS (WIDE_REGS)
    ) u_cls (
        .selected (selected),
        .sw_mode  (sw_mode),
        .wr_n     (wr_n),
        .av_n     (av_n),
        .opcode   (ac_bus[AC_W-1 -: OP_W]),
        .reg_idx  (ac_bus[IDX_W-1:0]),
        .seg_hi   (seg_hi),
        .req      (cls_req),
        .is_read  (cls_read)
    );

    always_comb begin
        s_d     = s_q;
        s_d.req = '0;
        if (fall) begin
            s_d.req       = cls_req;
            s_d.seg       = seg_hi;
            s_d.wdata     = dq_in;
            s_d.ent_valid = !vb_n;
            s_d.instr     = dq_in[INSTR_W-1:0];
            if (sw_mode)    s_d.addr = '0;
            else if (av_n)  s_d.addr = {{PAD_W{1'b0}}, ac_bus[IDX_W-1:0]};
            else            s_d.addr = ac_bus;
            s_d.oe        = !strobe_n && cls_read;
            s_d.vb_drive  = !strobe_n && cls_req.mem_rd;
        end else begin
            s_d.oe       = !strobe_n && s_q.oe;
            s_d.vb_drive = !strobe_n && s_q.vb_drive;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_wr      = s_q.req.mem_wr;
    assign mem_rd      = s_q.req.mem_rd;
    assign reg_wr      = s_q.req.reg_wr;
    assign reg_rd      = s_q.req.reg_rd;
    assign cmp_req     = s_q.req.cmp;
    assign move_req    = s_q.req.move;
    assign sw_instr    = s_q.req.sw_instr;
    assign sw_data_wr  = s_q.req.sw_dwr;
    assign sw_data_rd  = s_q.req.sw_drd;
    assign tgt_addr    = s_q.addr;
    assign seg_sel     = s_q.seg;
    assign wr_data     = s_q.wdata;
    assign entry_valid = s_q.ent_valid;
    assign instr_code  = s_q.instr;
    assign dq_out      = rd_data;
    assign dq_oe       = s_q.oe;
    assign vb_out_n    = rd_vb_n;
    assign vb_oe       = s_q.vb_drive;
endmodule

// File: rtl/cam_bus_decoder_chk.sv
module cam_bus_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_mode,
    input logic strobe_n,
    input logic sel_a_n,
    input logic sel_b_n,
    input logic mem_wr,
    input logic mem_rd,
    input logic reg_wr,
    input logic reg_rd,
    input logic cmp_req,
    input logic move_req,
    input logic sw_instr,
    input logic sw_data_wr,
    input logic sw_data_rd,
    input logic dq_oe,
    input logic vb_oe
);
    logic       strobe_prev_q;
    logic [8:0] reqs;
    logic       edge_seen;

    assign reqs = {mem_wr, mem_rd, reg_wr, reg_rd, cmp_req, move_req,
                   sw_instr, sw_data_wr, sw_data_rd};
    assign edge_seen = strobe_prev_q && !strobe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev_q <= 1'b1;
        else        strobe_prev_q <= strobe_n;
    end

    // R2
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reqs != 9'd0) |=> (reqs == 9'd0));

    // R3
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && sel_a_n && sel_b_n) |=> (reqs == 9'd0 && !dq_oe));

    // R2
    no_edge_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_seen |=> (reqs == 9'd0));

    // R9
    vb_needs_dq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vb_oe |-> dq_oe);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> !dq_oe);

    // R10
    sw_no_hw_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && sw_mode) |=> !(mem_wr || mem_rd || reg_wr || reg_rd || cmp_req || move_req));
endmodule

bind cam_bus_decoder cam_bus_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_mode    (sw_mode),
    .strobe_n   (strobe_n),
    .sel_a_n    (sel_a_n),
    .sel_b_n    (sel_b_n),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .cmp_req    (cmp_req),
    .move_req   (move_req),
    .sw_instr   (sw_instr),
    .sw_data_wr (sw_data_wr),
    .sw_data_rd (sw_data_rd),
    .dq_oe      (dq_oe),
    .vb_oe      (vb_oe)
);

// File: tb/sim_cam_bus_decoder.sv
module sim_cam_bus_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_mode = 1'b0, strobe_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1;
    logic        wr_n = 1'b1, av_n = 1'b1, seg_hi = 1'b0, vb_n = 1'b1, rd_vb_n = 1'b0;
    logic [12:0] ac_bus = '0;
    logic [31:0] dq_in = '0, rd_data = 32'hC0DE_5A5A;
    logic        mem_wr, mem_rd, reg_wr, reg_rd, cmp_req, move_req;
    logic        sw_instr, sw_data_wr, sw_data_rd, seg_sel, entry_valid;
    logic        dq_oe, vb_out_n, vb_oe;
    logic [12:0] tgt_addr;
    logic [31:0] wr_data, dq_out;
    logic [11:0] instr_code;

    cam_bus_decoder u0 (.*);

    always #5 clk = ~clk;

    int    checks = 0, fails = 0;
    string cur_req = "R1";

    // reference model state
    bit        m_prev = 1'b1;
    bit [8:0]  e_req = '0;
    bit        e_oe = 1'b0, e_vboe = 1'b0, e_seg = 1'b0, e_ent = 1'b0;
    bit [12:0] e_addr = '0;
    bit [31:0] e_wdata = '0;
    bit [11:0] e_instr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1'b1; e_req = '0; e_oe = 1'b0; e_vboe = 1'b0;
        end else begin
            bit is_fall;
            is_fall = m_prev && !strobe_n;
            e_req = '0;
            if (is_fall) begin
                int op, idx;
                bit rd;
                op  = int'(ac_bus) / 512;
                idx = int'(ac_bus) % 16;
                if (!sel_a_n || !sel_b_n) begin
                    if (sw_mode) begin
                        if (av_n && !wr_n) e_req[2] = 1'b1;
                        else if (!av_n) begin
                            if (wr_n) e_req[0] = 1'b1; else e_req[1] = 1'b1;
                        end
                    end else if (!av_n) begin
                        if (wr_n) e_req[7] = 1'b1; else e_req[8] = 1'b1;
                    end else if (op == 1) begin
                        if (!seg_hi || idx < 9) begin
                            if (wr_n) e_req[5] = 1'b1; else e_req[6] = 1'b1;
                        end
                    end else if (op == 2) begin
                        if (!wr_n) e_req[4] = 1'b1;
                    end else if (op == 3) e_req[3] = 1'b1;
                end
                e_seg = seg_hi; e_ent = !vb_n; e_wdata = dq_in; e_instr = dq_in[11:0];
                e_addr = sw_mode ? 13'd0 : (av_n ? 13'(idx) : ac_bus);
                rd = e_req[7] || e_req[5] || e_req[0];
                e_oe = !strobe_n && rd;
                e_vboe = !strobe_n && e_req[7];
            end else begin
                e_oe = !strobe_n && e_oe;
                e_vboe = !strobe_n && e_vboe;
            end
            m_prev = strobe_n;
        end
    end

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [8:0] a_req;
        a_req = {mem_wr, mem_rd, reg_wr, reg_rd, cmp_req, move_req,
                 sw_instr, sw_data_wr, sw_data_rd};
        check("requests", 64'(a_req), 64'(e_req));
        check("dq_oe", 64'(dq_oe), 64'(e_oe));
        check("vb_oe", 64'(vb_oe), 64'(e_vboe));
        if (e_oe) begin
            check("dq_out", 64'(dq_out), 64'(rd_data));
            if (e_vboe) check("vb_out_n", 64'(vb_out_n), 64'(rd_vb_n));
        end
        if (e_req != 0) begin
            check("tgt_addr", 64'(tgt_addr), 64'(e_addr));
            check("seg_sel", 64'(seg_sel), 64'(e_seg));
            if (e_req[8]) check("entry_valid", 64'(entry_valid), 64'(e_ent));
            if (e_req[8] || e_req[6] || e_req[4] || e_req[1])
                check("wr_data", 64'(wr_data), 64'(e_wdata));
            if (e_req[2]) check("instr_code", 64'(instr_code), 64'(e_instr));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic bus(input bit sw, input bit sa, input bit sb, input bit w,
                       input bit av, input logic [12:0] ac, input bit seg,
                       input bit vb, input logic [31:0] d, input int hold);
        @(posedge clk); #2;
        sw_mode = sw; sel_a_n = sa; sel_b_n = sb; wr_n = w; av_n = av;
        ac_bus = ac; seg_hi = seg; vb_n = vb; dq_in = d; strobe_n = 1'b1;
        @(posedge clk); #2;
        strobe_n = 1'b0;
        for (int i = 0; i < hold; i++) @(posedge clk);
        #2;
        strobe_n = 1'b1;
        idle(2);
    endtask

    function automatic logic [12:0] ctl(input int op, input int idx);
        return 13'((op << 9) | idx);
    endfunction

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(2);
        cur_req = "R4";
        bus(0, 0, 1, 0, 0, 13'h1FFF, 0, 0, 32'hDEAD_BEEF, 2);
        bus(0, 0, 1, 0, 0, 13'h0ABC, 0, 1, 32'h1234_5678, 2);
        cur_req = "R9";
        rd_vb_n = 1'b1;
        bus(0, 1, 0, 1, 0, 13'h0123, 1, 0, 32'h0, 4);
        cur_req = "R2";
        bus(0, 0, 0, 0, 0, 13'h0042, 0, 0, 32'hAAAA_5555, 12);
        cur_req = "R3";
        bus(0, 1, 1, 0, 0, 13'h0007, 0, 0, 32'h1, 3);
        bus(0, 1, 1, 1, 0, 13'h0007, 0, 0, 32'h1, 3);
        cur_req = "R5";
        bus(0, 0, 1, 0, 1, ctl(1, 3), 0, 1, 32'hFEED_0001, 2);
        bus(0, 0, 1, 1, 1, ctl(1, 12), 0, 1, 32'h0, 3);
        cur_req = "R8";
        bus(0, 0, 1, 0, 1, ctl(1, 8), 1, 1, 32'h0808_0808, 2);
        bus(0, 0, 1, 0, 1, ctl(1, 9), 1, 1, 32'h0909_0909, 2);
        bus(0, 0, 1, 1, 1, ctl(1, 15), 1, 1, 32'h0, 2);
        cur_req = "R6";
        bus(0, 0, 1, 0, 1, ctl(2, 0), 1, 1, 32'hCAFE_F00D, 2);
        bus(0, 0, 1, 0, 1, ctl(3, 5), 0, 1, 32'h0, 2);
        bus(0, 0, 1, 1, 1, ctl(3, 6), 0, 1, 32'h0, 2);
        cur_req = "R7";
        bus(0, 0, 1, 1, 1, ctl(2, 0), 0, 1, 32'h0, 3);
        for (int op = 4; op < 16; op += 3)
            bus(0, 0, 1, 0, 1, ctl(op, 1), 0, 1, 32'h0, 2);
        bus(0, 0, 1, 1, 1, ctl(0, 2), 0, 1, 32'h0, 2);
        cur_req = "R10";
        bus(1, 0, 1, 0, 1, 13'h1555, 0, 1, 32'hFFFF_F3A5, 2);
        bus(1, 0, 1, 1, 1, 13'h0400, 0, 1, 32'h0, 2);
        bus(1, 0, 1, 0, 0, 13'h1FFF, 1, 1, 32'h7777_8888, 2);
        bus(1, 1, 0, 1, 0, 13'h0001, 0, 1, 32'h0, 3);
        cur_req = "R1";
        @(posedge clk); #2;
        strobe_n = 1'b0; sw_mode = 1'b0; av_n = 1'b0; wr_n = 1'b1; sel_a_n = 1'b0;
        idle(1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        strobe_n = 1'b1;
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule